// File: doc/BRIEF.md
# Clock Snapshot Register File

This block holds the host-visible register map of a timekeeping unit: twenty byte-wide registers. The lowest eight are clock bytes and the other twelve are general registers. The clock bytes exist twice. An internal copy follows the external counter, and a user copy is what the host reads. On each rollover pulse, the counter's incremented time is loaded into the internal copy. All eight internal bytes are then copied into the user copy in one clock cycle, so a reader never sees a half-updated time.

That copy is held back in two situations. The first is while the host reads clock bytes, so a multi-byte read returns one consistent instant. The second is while a power-fail halt flag is set, so the user copy keeps the time of the power loss. A rollover that arrives while the copy is held back is not dropped. The first copy after the hold ends carries the newest internal time.

The host side is a plain byte port with an address pointer that steps after every access, plus a strobe that marks the end of a bus transaction. A host write to a clock byte updates both copies of that byte. It also pulses a reset request toward the counter's divider chain. The time bytes are meant to hold BCD and the general bytes plain binary. The block stores both kinds as written.

Top module: `snap_regfile`

## Requirements
- R1: After reset, every register, the internal time, the pointer, `rd_valid_o` and `div_rst_o` are zero.
- R2: A `ptr_load_i` cycle sets the pointer. Each accepted read or write then advances it by one, and the pointer wraps from 13h to 00h. Priority is load, then write, then read, and only one of them acts in a cycle.
- R3: A read returns the byte at the pointer on `rd_data_o` in the next cycle. `rd_valid_o` is high for exactly that one cycle.
- R4: On a `tick_i` cycle, `int_time_o` takes `inc_time_i` at the next edge, where byte k is bits [8k+7:8k]. When no hold is active, all eight user bytes take the internal copy at the following edge.
- R5: A read at address 00h–07h holds back the copy in its own cycle. It also sets a lock that keeps holding back the copy until `stop_i` is seen, or until a read or write leaves the pointer at 08h or above.
- R6: Rollovers seen during a hold stay pending. The first copy after the hold ends delivers the most recent internal time.
- R7: A `power_fail_i` pulse sets the halt bit, which is bit 6 of register 0Ch. While that bit is set, the user copy does not follow the internal copy.
- R8: Writing register 0Ch with bit 6 at 0 clears the halt. The pending newest time then reaches the user copy.
- R9: A write to address 01h–07h stores the byte in both the internal and the user copy. `div_rst_o` is high for one cycle, in the cycle after the write.
- R10: A write to address 00h stores 00h, whatever the data.
- R11: Registers 08h–13h read back what was last written, and rollovers leave them untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Rollover pulse from the counter |
| inc_time_i | input | 64 | Incremented time from the counter, byte k at [8k+7:8k] |
| int_time_o | output | 64 | Internal clock copy, fed back to the counter |
| power_fail_i | input | 1 | Power-fail pulse, sets the halt bit |
| div_rst_o | output | 1 | Divider-chain reset request after a clock write |
| ptr_load_i | input | 1 | Load the address pointer |
| ptr_addr_i | input | 5 | Pointer value to load |
| wr_en_i | input | 1 | Write one byte at the pointer |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read one byte at the pointer |
| stop_i | input | 1 | End-of-transaction strobe, releases the read lock |
| rd_data_o | output | 8 | Read data |
| rd_valid_o | output | 1 | Read data valid |

## Verification
The hardest case to reach is a rollover that is lost or delivered stale because it landed inside a hold. The stimulus opens a read lock at a mid-clock address and issues two rollovers with different times while the lock is held. It re-reads a clock byte to show the old value is still there. It then releases the lock in two ways, with the stop strobe and by reading past 07h, and expects only the later time afterwards. The same pattern is repeated with the power-fail halt, which is released by a host write of register 0Ch.

// File: rtl/snap_pkg.sv
package snap_pkg;
   // host operation chosen for the current cycle
   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_LOAD = 2'd1,
      OP_WR   = 2'd2,
      OP_RD   = 2'd3
   } host_op_e;
endpackage

// File: rtl/snap_ptr.sv
module snap_ptr
   import snap_pkg::*;
#(
   parameter  int unsigned N_REG = 20,
   parameter  int unsigned N_CLK = 8,
   localparam int unsigned AW    = $clog2(N_REG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ptr_load_i,
   input  logic [AW-1:0] ptr_addr_i,
   input  logic          wr_en_i,
   input  logic          rd_en_i,
   input  logic          stop_i,
   output logic [AW-1:0] ptr_o,
   output host_op_e      op_o,
   output logic          is_clk_o,
   output logic          lock_o,
   output logic          rd_clk_o
);
   logic [AW-1:0] ptr_q, ptr_nxt, load_addr;
   logic          lock_q, nxt_is_clk;
   host_op_e      op;

   always_comb begin
      op = OP_IDLE;
      if (ptr_load_i)   op = OP_LOAD;
      else if (wr_en_i) op = OP_WR;
      else if (rd_en_i) op = OP_RD;
   end

   assign ptr_nxt    = (ptr_q == AW'(N_REG - 1)) ? '0 : ptr_q + AW'(1);
   assign nxt_is_clk = ptr_nxt < AW'(N_CLK);
   assign load_addr  = (ptr_addr_i < AW'(N_REG)) ? ptr_addr_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         lock_q <= 1'b0;
      end else begin
         case (op)
            OP_LOAD:      ptr_q <= load_addr;
            OP_WR, OP_RD: ptr_q <= ptr_nxt;
            default:      ptr_q <= ptr_q;
         endcase
         if (stop_i)
            lock_q <= 1'b0;
         else if (op == OP_WR || op == OP_RD)
            lock_q <= (lock_q || (op == OP_RD && is_clk_o)) && nxt_is_clk;
      end
   end

   assign ptr_o    = ptr_q;
   assign op_o     = op;
   assign is_clk_o = ptr_q < AW'(N_CLK);
   assign lock_o   = lock_q;
   assign rd_clk_o = (op == OP_RD) && is_clk_o;
endmodule

// File: rtl/snap_clk_bank.sv
module snap_clk_bank #(
   parameter  int unsigned N_CLK    = 8,
   parameter  int unsigned DW       = 8,
   parameter  bit          ZERO_SUB = 1'b1,
   localparam int unsigned CIW      = (N_CLK > 1) ? $clog2(N_CLK) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_i,
   input  logic [N_CLK*DW-1:0] inc_i,
   input  logic                wr_i,
   input  logic [CIW-1:0]      wr_idx_i,
   input  logic [DW-1:0]       wr_data_i,
   input  logic                freeze_i,
   output logic [N_CLK*DW-1:0] int_o,
   output logic [N_CLK*DW-1:0] usr_o,
   output logic                pend_o
);
   logic pend_q, xfer;

   assign xfer = pend_q && !freeze_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= tick_i || (pend_q && !xfer);
   end

   for (genvar g = 0; g < N_CLK; g++) begin : g_byte
      logic [DW-1:0] int_q, usr_q, wval;
      logic          hit;

      assign hit = wr_i && (wr_idx_i == CIW'(g));

      if (g == 0 && ZERO_SUB) begin : g_zero
         assign wval = '0;
      end else begin : g_data
         assign wval = wr_data_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            int_q <= '0;
            usr_q <= '0;
         end else begin
            if (hit) begin
               int_q <= wval;
               usr_q <= wval;
            end else begin
               if (tick_i) int_q <= inc_i[g*DW +: DW];
               if (xfer)   usr_q <= int_q;
            end
         end
      end

      assign int_o[g*DW +: DW] = int_q;
      assign usr_o[g*DW +: DW] = usr_q;
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/snap_aux_bank.sv
module snap_aux_bank #(
   parameter  int unsigned N_AUX    = 12,
   parameter  int unsigned DW       = 8,
   parameter  int unsigned HALT_IDX = 4,
   parameter  int unsigned HALT_BIT = 6,
   localparam int unsigned AIW      = (N_AUX > 1) ? $clog2(N_AUX) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_i,
   input  logic [AIW-1:0]      wr_idx_i,
   input  logic [DW-1:0]       wr_data_i,
   input  logic                pf_i,
   output logic [N_AUX*DW-1:0] aux_o,
   output logic                halt_o
);
   for (genvar g = 0; g < N_AUX; g++) begin : g_reg
      logic [DW-1:0] q, d;

      if (g == HALT_IDX) begin : g_halt
         always_comb begin
            d = (wr_i && wr_idx_i == AIW'(g)) ? wr_data_i : q;
            if (pf_i) d[HALT_BIT] = 1'b1;
         end
      end else begin : g_plain
         assign d = (wr_i && wr_idx_i == AIW'(g)) ? wr_data_i : q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end

      assign aux_o[g*DW +: DW] = q;
   end

   assign halt_o = aux_o[HALT_IDX*DW + HALT_BIT];
endmodule

// File: rtl/snap_regfile.sv
module snap_regfile
   import snap_pkg::*;
#(
   parameter  int unsigned N_REG     = 20,
   parameter  int unsigned N_CLK     = 8,
   parameter  int unsigned DW        = 8,
   parameter  int unsigned HALT_ADDR = 12,
   parameter  int unsigned HALT_BIT  = 6,
   parameter  bit          ZERO_SUB  = 1'b1,
   localparam int unsigned AW        = $clog2(N_REG)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_i,
   input  logic [N_CLK*DW-1:0] inc_time_i,
   output logic [N_CLK*DW-1:0] int_time_o,
   input  logic                power_fail_i,
   output logic                div_rst_o,
   input  logic                ptr_load_i,
   input  logic [AW-1:0]       ptr_addr_i,
   input  logic                wr_en_i,
   input  logic [DW-1:0]       wr_data_i,
   input  logic                rd_en_i,
   input  logic                stop_i,
   output logic [DW-1:0]       rd_data_o,
   output logic                rd_valid_o
);
   localparam int unsigned N_AUX = N_REG - N_CLK;
   localparam int unsigned CIW   = (N_CLK > 1) ? $clog2(N_CLK) : 1;
   localparam int unsigned AIW   = (N_AUX > 1) ? $clog2(N_AUX) : 1;

   if (N_CLK < 2 || N_CLK + 2 > N_REG) begin : g_bad_split
      $error("snap_regfile: N_CLK must be at least 2 and leave two general registers");
   end
   if (HALT_ADDR < N_CLK || HALT_ADDR >= N_REG) begin : g_bad_halt
      $error("snap_regfile: HALT_ADDR must be a general register");
   end
   if (HALT_BIT >= DW) begin : g_bad_bit
      $error("snap_regfile: HALT_BIT outside the byte");
   end

   logic [AW-1:0]       ptr;
   host_op_e            op;
   logic                is_clk, lock, rd_clk, halt, pend, freeze;
   logic                clk_wr, aux_wr, rd_go;
   logic [CIW-1:0]      clk_idx;
   logic [AIW-1:0]      aux_idx;
   logic [N_CLK*DW-1:0] usr_w, int_w;
   logic [N_AUX*DW-1:0] aux_w;
   logic [DW-1:0]       rd_byte, rd_q;
   logic                rd_v_q, div_q;

   snap_ptr #(.N_REG(N_REG), .N_CLK(N_CLK)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .ptr_load_i (ptr_load_i),
      .ptr_addr_i (ptr_addr_i),
      .wr_en_i    (wr_en_i),
      .rd_en_i    (rd_en_i),
      .stop_i     (stop_i),
      .ptr_o      (ptr),
      .op_o       (op),
      .is_clk_o   (is_clk),
      .lock_o     (lock),
      .rd_clk_o   (rd_clk)
   );

   assign clk_wr  = (op == OP_WR) && is_clk;
   assign aux_wr  = (op == OP_WR) && !is_clk;
   assign rd_go   = (op == OP_RD);
   assign clk_idx = CIW'(ptr);
   assign aux_idx = AIW'(ptr - AW'(N_CLK));
   assign freeze  = halt || lock || rd_clk;

   snap_clk_bank #(.N_CLK(N_CLK), .DW(DW), .ZERO_SUB(ZERO_SUB)) u_clk (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .inc_i     (inc_time_i),
      .wr_i      (clk_wr),
      .wr_idx_i  (clk_idx),
      .wr_data_i (wr_data_i),
      .freeze_i  (freeze),
      .int_o     (int_w),
      .usr_o     (usr_w),
      .pend_o    (pend)
   );

   snap_aux_bank #(
      .N_AUX(N_AUX), .DW(DW), .HALT_IDX(HALT_ADDR - N_CLK), .HALT_BIT(HALT_BIT)
   ) u_aux (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (aux_wr),
      .wr_idx_i  (aux_idx),
      .wr_data_i (wr_data_i),
      .pf_i      (power_fail_i),
      .aux_o     (aux_w),
      .halt_o    (halt)
   );

   always_comb begin
      rd_byte = '0;
      if (is_clk)
         rd_byte = usr_w[clk_idx*DW +: DW];
      else if (int'(aux_idx) < int'(N_AUX))
         rd_byte = aux_w[aux_idx*DW +: DW];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q   <= '0;
         rd_v_q <= 1'b0;
         div_q  <= 1'b0;
      end else begin
         rd_v_q <= rd_go;
         div_q  <= clk_wr;
         if (rd_go) rd_q <= rd_byte;
      end
   end

   assign rd_data_o  = rd_q;
   assign rd_valid_o = rd_v_q;
   assign div_rst_o  = div_q;
   assign int_time_o = int_w;
endmodule

// File: rtl/snap_regfile_chk.sv
module snap_regfile_chk #(
   parameter  int unsigned N_REG = 20,
   parameter  int unsigned N_CLK = 8,
   parameter  int unsigned DW    = 8,
   localparam int unsigned AW    = $clog2(N_REG)
) (
   input logic                clk,
   input logic                rst_n,
   input logic [N_CLK*DW-1:0] usr_w,
   input logic [N_CLK*DW-1:0] int_w,
   input logic                halt,
   input logic                lock,
   input logic                freeze,
   input logic                pend,
   input logic                tick,
   input logic                pf,
   input logic                clk_wr,
   input logic                div_rst,
   input logic                rd_go,
   input logic                rd_valid,
   input logic [AW-1:0]       ptr
);
   // R2: pointer stays inside the map
   a_r2_ptr_in_map: assert property (@(posedge clk) disable iff (!rst_n)
      ptr < AW'(N_REG));

   // R3: a read produces valid data next cycle
   a_r3_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go |=> rd_valid);

   // R4: an unblocked pending transfer copies the whole internal word
   a_r4_atomic_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !freeze && !clk_wr) |=> (usr_w == $past(int_w)));

   // R5: the read lock keeps the user copy still
   a_r5_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && !clk_wr) |=> $stable(usr_w));

   // R6: a rollover is always remembered
   a_r6_tick_pending: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> pend);

   // R7: power fail sets the halt, and the halt keeps the user copy still
   a_r7_pf_halts: assert property (@(posedge clk) disable iff (!rst_n)
      pf |=> halt);
   a_r7_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !clk_wr) |=> $stable(usr_w));

   // R9: a clock write requests a divider reset
   a_r9_div_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      clk_wr |=> div_rst);
endmodule

bind snap_regfile snap_regfile_chk #(.N_REG(N_REG), .N_CLK(N_CLK), .DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .usr_w    (usr_w),
   .int_w    (int_w),
   .halt     (halt),
   .lock     (lock),
   .freeze   (freeze),
   .pend     (pend),
   .tick     (tick_i),
   .pf       (power_fail_i),
   .clk_wr   (clk_wr),
   .div_rst  (div_rst_o),
   .rd_go    (rd_go),
   .rd_valid (rd_valid_o),
   .ptr      (ptr)
);

// File: tb/sim_snap_regfile.sv
`timescale 1ns/1ps
module sim_snap_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic [63:0] inc_time_i = '0;
   logic [63:0] int_time_o;
   logic        power_fail_i = 1'b0;
   logic        div_rst_o;
   logic        ptr_load_i = 1'b0;
   logic [4:0]  ptr_addr_i = '0;
   logic        wr_en_i = 1'b0;
   logic [7:0]  wr_data_i = '0;
   logic        rd_en_i = 1'b0;
   logic        stop_i = 1'b0;
   logic [7:0]  rd_data_o;
   logic        rd_valid_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [7:0] exq[$];
   string      tgq[$];

   always #10 clk = ~clk;

   snap_regfile u0 (.*);

   function automatic logic [7:0] bt(input logic [63:0] v, input int i);
      return v[i*8 +: 8];
   endfunction

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever read data is presented
   always @(negedge clk) begin
      if (rst_n && rd_valid_o) begin
         if (exq.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R3: actual unexpected read %h expected none", rd_data_o);
         end else begin
            automatic logic [7:0] e = exq.pop_front();
            automatic string t = tgq.pop_front();
            chk(t, {56'h0, rd_data_o}, {56'h0, e});
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic op_load(input int a);
      ptr_load_i = 1'b1; ptr_addr_i = 5'(a);
      @(negedge clk); ptr_load_i = 1'b0;
   endtask
   task automatic op_wr(input logic [7:0] d);
      wr_en_i = 1'b1; wr_data_i = d;
      @(negedge clk); wr_en_i = 1'b0;
   endtask
   task automatic op_rd(input logic [7:0] e, input string tag);
      exq.push_back(e); tgq.push_back(tag);
      rd_en_i = 1'b1;
      @(negedge clk); rd_en_i = 1'b0;
   endtask
   task automatic pulse_tick(input logic [63:0] v);
      inc_time_i = v; tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
   endtask
   task automatic pulse_pf();
      power_fail_i = 1'b1;
      @(negedge clk); power_fail_i = 1'b0;
   endtask
   task automatic pulse_stop();
      stop_i = 1'b1;
      @(negedge clk); stop_i = 1'b0;
   endtask

   localparam logic [63:0] T1 = 64'h24_12_31_07_23_59_59_00;
   localparam logic [63:0] T2 = 64'h25_01_01_01_00_00_00_00;
   localparam logic [63:0] T3 = 64'h25_01_01_01_00_00_01_00;
   localparam logic [63:0] T4 = 64'h25_02_14_05_12_34_56_00;
   localparam logic [63:0] T5 = 64'h25_02_14_05_12_35_07_00;
   localparam logic [63:0] T6 = 64'h26_06_30_02_18_45_33_00;

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1: reset state
      chk("R1 valid", {63'h0, rd_valid_o}, 64'h0);
      chk("R1 divrst", {63'h0, div_rst_o}, 64'h0);
      chk("R1 internal", int_time_o, 64'h0);
      op_load(0);
      op_rd(8'h00, "R1 user byte0");
      // R3: valid lasts one cycle
      idle(1);
      chk("R3 valid pulse", {63'h0, rd_valid_o}, 64'h0);
      pulse_stop();

      // R4: rollover and atomic copy
      pulse_tick(T1);
      chk("R4 internal", int_time_o, T1);
      idle(1);
      op_load(1);
      for (int i = 1; i < 8; i++) op_rd(bt(T1, i), "R4 user copy");

      // R5/R6: lock from a clock read, two rollovers, release by stop
      op_load(2);
      op_rd(bt(T1, 2), "R5 lock read");
      pulse_tick(T2);
      pulse_tick(T3);
      idle(3);
      op_rd(bt(T1, 3), "R5 frozen under lock");
      pulse_stop();
      idle(2);
      op_load(3);
      op_rd(bt(T3, 3), "R6 latest after stop");
      pulse_stop();

      // R5: lock released by leaving the clock range
      op_load(6);
      op_rd(bt(T3, 6), "R5 read 06h");
      op_rd(bt(T3, 7), "R5 read 07h");
      pulse_tick(T4);
      idle(2);
      op_load(4);
      op_rd(bt(T4, 4), "R5 released by pointer");
      pulse_stop();

      // R7/R8: power-fail halt
      pulse_pf();
      op_load(12);
      op_rd(8'h40, "R7 halt bit");
      pulse_tick(T5);
      idle(3);
      op_load(1);
      op_rd(bt(T4, 1), "R7 frozen by halt");
      pulse_stop();
      op_load(12);
      op_wr(8'h00);
      idle(2);
      op_load(1);
      op_rd(bt(T5, 1), "R8 resume after clear");
      pulse_stop();

      // R9: clock write
      op_load(5);
      op_wr(8'h27);
      chk("R9 divrst high", {63'h0, div_rst_o}, 64'h1);
      chk("R9 internal byte", {56'h0, bt(int_time_o, 5)}, 64'h27);
      idle(1);
      chk("R9 divrst one cycle", {63'h0, div_rst_o}, 64'h0);
      op_load(5);
      op_rd(8'h27, "R9 user byte");
      pulse_stop();

      // R10: sub-second byte forced to zero
      op_load(0);
      op_wr(8'h99);
      chk("R10 internal byte0", {56'h0, bt(int_time_o, 0)}, 64'h0);
      op_load(0);
      op_rd(8'h00, "R10 user byte0");
      pulse_stop();

      // R2: wrap from 13h to 00h
      op_load(18);
      op_wr(8'hA1);
      op_wr(8'hB2);
      op_rd(8'h00, "R2 wrap to 00h");
      op_rd(bt(T5, 1), "R2 step to 01h");
      pulse_stop();
      op_load(18);
      op_rd(8'hA1, "R11 reg 12h");
      op_rd(8'hB2, "R11 reg 13h");

      // R11: rollover leaves general registers alone
      pulse_tick(T6);
      idle(3);
      op_load(19);
      op_rd(8'hB2, "R11 after rollover");
      op_load(1);
      op_rd(bt(T6, 1), "R4 copy after rollover");
      pulse_stop();

      idle(3);
      chk("R3 scoreboard drained", 64'(exq.size()), 64'h0);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule